// File: doc/BRIEF.md
# Binary base-two logarithm converter

This block turns a 16-bit unsigned integer into an approximate base-two logarithm in fixed point. The integer field of the result is the position of the highest set bit of the input. The fractional field is the group of input bits that sit below that leading one, shifted up so that they start at the top of the fraction. The approximation is piecewise linear: log2(1 + m) is replaced by m, and nothing corrects the result afterwards. A separate flag marks an all-zero input, which has no logarithm.

The conversion path is combinational. The leading-one search is a two-level tree of small group detectors. The normalisation is a barrel shifter whose shift amount comes from the encoded leading-one position. The result is captured in a single output register. The input side carries a valid strobe, and the output side raises its own valid one clock later. A typical use is to turn multiplies and divides in a signal-processing datapath into adds and subtracts.

Top module: `binlog_unit`

## Requirements
- R1: For a nonzero input sampled with `in_valid` high, `out_int` equals the bit index (0 to 15) of the most significant 1 of that input.
- R2: For a nonzero input, `out_frac` (15 bits) holds the input bits below the leading one, left-aligned: bit 14 of `out_frac` is the input bit just under the leading one. It equals the low 15 bits of the input shifted left by (15 − `out_int`), with no correction term. For example, input 29 gives `out_int` = 4 and `out_frac` = 0x6800.
- R3: An all-zero input sampled with `in_valid` high sets `out_zero` to 1, and forces `out_int` and `out_frac` to 0.
- R4: Any nonzero input clears `out_zero`. Input 1 gives `out_int` = 0, `out_frac` = 0 and `out_zero` = 0.
- R5: Any power of two 2^k gives `out_int` = k and `out_frac` = 0.
- R6: `out_valid` in each cycle equals `in_valid` one clock earlier. The result for an input sampled at a clock edge is visible right after that same edge.
- R7: When `in_valid` is low at a clock edge, `out_int`, `out_frac` and `out_zero` keep their values, whatever `in_data` holds.
- R8: While the active-high synchronous reset `rst` is high at a clock edge, `out_valid`, `out_int`, `out_frac` and `out_zero` are all cleared to 0.
- R9: For every nonzero input d, the value `out_int` + `out_frac`/2^15 is never above log2(d) and falls short of it by less than 0.087.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` at this edge |
| in_data | input | 16 | Unsigned operand |
| out_valid | output | 1 | Result register holds a fresh conversion |
| out_int | output | 4 | Integer part of the logarithm |
| out_frac | output | 15 | Fractional part, left-aligned mantissa |
| out_zero | output | 1 | Operand was zero |

## Verification
The bench sweeps every one of the 65536 operands back to back. A wrong leading-one tree, for example one that picks the lowest group that reports a hit, would then show wrong integer fields on the inputs that have bits in more than one group. A shifter whose shift amount is off by one stage would leave the leading one in bit 14 of the fraction, or drop the top mantissa bit, and the powers of two and input 1 expose that at once. The zero operand checks that the flag is raised and the fields are forced to zero, rather than left with whatever the empty search produces. Finally, deasserting `in_valid` while the data changes, and raising reset with data present, catch an output register that loads on every edge or ignores reset.

// File: rtl/binlog_pkg.sv
package binlog_pkg;

   // Barrel shifter construction variants
   typedef enum logic {
      SHIFT_MUX_CASCADE = 1'b0,  // log2(N) stages of 2:1 muxes
      SHIFT_DIRECT      = 1'b1   // single variable shift, left to synthesis
   } shift_style_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lead_one_group.sv
// Small leading-one detector: reports whether any bit is set and the
// index of the highest set bit. Used both for the groups and for the
// group-select level of the tree.
module lead_one_group #(
   parameter int unsigned W  = 4,
   localparam int unsigned PW = $clog2(W)
) (
   input  logic [W-1:0]  bits,
   output logic          found,
   output logic [PW-1:0] pos
);

   generate
      if (W < 2 || !binlog_pkg::is_pow2(W)) begin : g_bad_w
         $error("lead_one_group: W must be a power of two of at least 2");
      end
   endgenerate

   always_comb begin
      found = |bits;
      pos   = '0;
      // ascending scan: a later (higher) hit overrides an earlier one
      for (int i = 0; i < W; i++) begin
         if (bits[i]) begin
            pos = PW'(i);
         end
      end
   end

endmodule

// File: rtl/lead_one_tree.sv
// Two-level leading-one detector: GROUP_W-bit detectors on the slices of
// the operand, then a detector over their found flags to pick the group.
module lead_one_tree #(
   parameter int unsigned IN_W    = 16,
   parameter int unsigned GROUP_W = 4,
   localparam int unsigned NG    = IN_W / GROUP_W,
   localparam int unsigned GPW   = $clog2(GROUP_W),
   localparam int unsigned IW    = $clog2(NG),
   localparam int unsigned POS_W = GPW + IW
) (
   input  logic [IN_W-1:0]  din,
   output logic             any_set,
   output logic [POS_W-1:0] lead_pos
);

   generate
      if (IN_W % GROUP_W != 0) begin : g_bad_split
         $error("lead_one_tree: IN_W must be a multiple of GROUP_W");
      end
      if (NG < 2) begin : g_bad_ng
         $error("lead_one_tree: at least two groups are required");
      end
   endgenerate

   logic [NG-1:0]          grp_found;
   logic [NG-1:0][GPW-1:0] grp_pos;
   logic [IW-1:0]          sel_idx;

   generate
      for (genvar g = 0; g < NG; g++) begin : g_grp
         lead_one_group #(
            .W(GROUP_W)
         ) i_grp (
            .bits  (din[g*GROUP_W +: GROUP_W]),
            .found (grp_found[g]),
            .pos   (grp_pos[g])
         );
      end
   endgenerate

   // second level: the highest group that saw a one wins
   lead_one_group #(
      .W(NG)
   ) i_sel (
      .bits  (grp_found),
      .found (any_set),
      .pos   (sel_idx)
   );

   assign lead_pos = {sel_idx, grp_pos[sel_idx]};

endmodule

// File: rtl/mant_shifter.sv
// Left-aligns the operand so the leading one lands in the top bit, then
// drops it; what remains is the linear mantissa used as the fraction.
module mant_shifter #(
   parameter int unsigned            IN_W  = 16,
   parameter binlog_pkg::shift_style_e STYLE = binlog_pkg::SHIFT_MUX_CASCADE,
   localparam int unsigned POS_W  = $clog2(IN_W),
   localparam int unsigned FRAC_W = IN_W - 1
) (
   input  logic [IN_W-1:0]   din,
   input  logic [POS_W-1:0]  lead_pos,
   output logic [FRAC_W-1:0] frac
);

   localparam logic [POS_W-1:0] TOP_IDX = POS_W'(IN_W - 1);

   logic [POS_W-1:0] shamt;
   logic [IN_W-1:0]  aligned;

   assign shamt = TOP_IDX - lead_pos;

   generate
      if (STYLE == binlog_pkg::SHIFT_MUX_CASCADE) begin : g_mux
         logic [IN_W-1:0] stage [POS_W+1];
         assign stage[0] = din;
         for (genvar k = 0; k < POS_W; k++) begin : g_stage
            assign stage[k+1] = shamt[k] ? (stage[k] << (2**k)) : stage[k];
         end
         assign aligned = stage[POS_W];
      end else begin : g_direct
         assign aligned = din << shamt;
      end
   endgenerate

   assign frac = aligned[FRAC_W-1:0];

endmodule

// File: rtl/binlog_unit.sv
// Base-two logarithm converter, one register stage.
module binlog_unit #(
   parameter int unsigned              IN_W        = 16,
   parameter int unsigned              GROUP_W     = 4,
   parameter binlog_pkg::shift_style_e SHIFT_STYLE = binlog_pkg::SHIFT_MUX_CASCADE,
   localparam int unsigned POS_W  = $clog2(IN_W),
   localparam int unsigned FRAC_W = IN_W - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_data,
   output logic              out_valid,
   output logic [POS_W-1:0]  out_int,
   output logic [FRAC_W-1:0] out_frac,
   output logic              out_zero
);

   generate
      if (!binlog_pkg::is_pow2(IN_W) || IN_W < 4) begin : g_bad_in_w
         $error("binlog_unit: IN_W must be a power of two of at least 4");
      end
      if (!binlog_pkg::is_pow2(GROUP_W) || GROUP_W >= IN_W) begin : g_bad_group
         $error("binlog_unit: GROUP_W must be a power of two below IN_W");
      end
   endgenerate

   logic              any_set;
   logic [POS_W-1:0]  lead_pos;
   logic [FRAC_W-1:0] mant;
   logic [POS_W-1:0]  int_c;
   logic [FRAC_W-1:0] frac_c;

   lead_one_tree #(
      .IN_W    (IN_W),
      .GROUP_W (GROUP_W)
   ) i_lod (
      .din      (in_data),
      .any_set  (any_set),
      .lead_pos (lead_pos)
   );

   mant_shifter #(
      .IN_W  (IN_W),
      .STYLE (SHIFT_STYLE)
   ) i_shift (
      .din      (in_data),
      .lead_pos (lead_pos),
      .frac     (mant)
   );

   // a zero operand has no leading one: force a clean all-zero result
   assign int_c  = any_set ? lead_pos : '0;
   assign frac_c = any_set ? mant     : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_int   <= '0;
         out_frac  <= '0;
         out_zero  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_int  <= int_c;
            out_frac <= frac_c;
            out_zero <= ~any_set;
         end
      end
   end

endmodule

// File: rtl/binlog_chk.sv
module binlog_chk #(
   parameter int unsigned IN_W = 16,
   localparam int unsigned POS_W  = $clog2(IN_W),
   localparam int unsigned FRAC_W = IN_W - 1
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [IN_W-1:0]   in_data,
   input logic              out_valid,
   input logic [POS_W-1:0]  out_int,
   input logic [FRAC_W-1:0] out_frac,
   input logic              out_zero
);

   function automatic logic [FRAC_W-1:0] expect_frac(
      input logic [IN_W-1:0] d, input logic [POS_W-1:0] p);
      logic [IN_W-1:0] t;
      t = d << (POS_W'(IN_W - 1) - p);
      return t[FRAC_W-1:0];
   endfunction

   // R1: the integer field addresses the top set bit of the sampled operand
   assert_int_is_msb_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_data != '0) |=> (($past(in_data) >> out_int) == IN_W'(1)));

   // R2: fraction is the aligned remainder below the leading one
   assert_frac_aligned_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_data != '0) |=> (out_frac == expect_frac($past(in_data), out_int)));

   // R3: zero operand raises the flag with cleared fields
   assert_zero_flag_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_data == '0) |=> (out_zero && out_int == '0 && out_frac == '0));

   // R4: nonzero operand clears the flag
   assert_nonzero_flag_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_data != '0) |=> !out_zero);

   // R6: valid tracks the input strobe by one clock
   assert_valid_rise_R6: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   assert_valid_fall_R6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R7: result fields hold without a strobe
   assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_int) && $stable(out_frac) && $stable(out_zero)));

   // R8: reset clears every output
   assert_reset_clear_R8: assert property (@(posedge clk)
      rst |=> (!out_valid && out_int == '0 && out_frac == '0 && !out_zero));

endmodule

bind binlog_unit binlog_chk #(
   .IN_W(IN_W)
) i_binlog_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_int   (out_int),
   .out_frac  (out_frac),
   .out_zero  (out_zero)
);

// File: tb/test_binlog_unit.sv
module test_binlog_unit;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_data  = '0;
   logic        out_valid;
   logic [3:0]  out_int;
   logic [14:0] out_frac;
   logic        out_zero;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   binlog_unit i_binlog_unit (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_int   (out_int),
      .out_frac  (out_frac),
      .out_zero  (out_zero)
   );

   // reference: top-down search for the first one, then shift by arithmetic
   function automatic logic [19:0] model(input logic [15:0] d);
      int p;
      logic [15:0] t;
      p = -1;
      for (int b = 15; b >= 0; b--) begin
         if (p < 0 && d[b]) p = b;
      end
      if (p < 0) return {1'b1, 4'd0, 15'd0};
      t = d * (16'd1 << (15 - p));
      return {1'b0, 4'(p), t[14:0]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   function automatic logic [19:0] outs();
      return {out_zero, out_int, out_frac};
   endfunction

   // drive at a falling edge, observe at the next falling edge
   task automatic step(input logic [15:0] d, input logic v);
      @(negedge clk);
      in_data  = d;
      in_valid = v;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 reset valid", 32'(out_valid), 0);
      chk("R8 reset fields", 32'(outs()), 0);
      rst = 1'b0;
   endtask

   task automatic t_example();
      step(16'd29, 1'b1);
      chk("R1 int of 29", 32'(out_int), 4);
      chk("R2 frac of 29", 32'(out_frac), 32'h6800);
   endtask

   task automatic t_zero();
      step(16'hFFFF, 1'b1);
      step(16'h0000, 1'b1);
      chk("R3 zero operand", 32'(outs()), 32'(20'h80000));
   endtask

   task automatic t_one();
      step(16'h0000, 1'b1);
      step(16'h0001, 1'b1);
      chk("R4 operand one", 32'(outs()), 0);
   endtask

   task automatic t_pow2();
      for (int k = 0; k < 16; k++) begin
         step(16'd1 << k, 1'b1);
         chk("R5 power of two", 32'(outs()), 32'(k) << 15);
      end
   endtask

   task automatic t_latency();
      step(16'd5, 1'b1);
      chk("R6 valid high", 32'(out_valid), 1);
      chk("R6 result same edge", 32'(outs()), 32'(model(16'd5)));
      step(16'd7, 1'b0);
      chk("R6 valid low", 32'(out_valid), 0);
      step(16'd9, 1'b1);
      chk("R6 valid again", 32'(out_valid), 1);
   endtask

   task automatic t_hold();
      step(16'h1234, 1'b1);
      chk("R7 loaded", 32'(outs()), 32'(model(16'h1234)));
      step(16'h0000, 1'b0);
      chk("R7 hold on zero data", 32'(outs()), 32'(model(16'h1234)));
      step(16'h0001, 1'b0);
      chk("R7 hold on other data", 32'(outs()), 32'(model(16'h1234)));
   endtask

   task automatic t_reset_mid();
      step(16'hFFFF, 1'b1);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R8 mid-run valid", 32'(out_valid), 0);
      chk("R8 mid-run fields", 32'(outs()), 0);
      rst = 1'b0;
      in_valid = 1'b0;
   endtask

   task automatic t_sweep();
      for (int i = 0; i <= 65536; i++) begin
         @(negedge clk);
         if (i > 0) begin
            chk("R1 R2 R3 sweep", {11'd0, out_valid, outs()},
                {11'd0, 1'b1, model(16'(i - 1))});
         end
         if (i < 65536) begin
            in_data  = 16'(i);
            in_valid = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
      end
   endtask

   task automatic t_error();
      int vals[8] = '{3, 29, 181, 1447, 23170, 46341, 65535, 5};
      foreach (vals[j]) begin
         real approx, truth, err;
         step(16'(vals[j]), 1'b1);
         approx = real'(out_int) + real'(out_frac) / 32768.0;
         truth  = $ln(real'(vals[j])) / $ln(2.0);
         err    = truth - approx;
         checks++;
         if (err < -1.0e-9 || err >= 0.087) begin
            fails++;
            $display("FAIL R9 error bound for %0d: actual %f expected %f", vals[j], approx, truth);
         end
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_example();
      t_zero();
      t_one();
      t_pow2();
      t_latency();
      t_hold();
      t_reset_mid();
      t_sweep();
      t_error();
      finish_run();
   end

endmodule